// File: doc/BRIEF.md
# Eight-bit Arithmetic-Logic Unit with Status Flags

This block is a purely combinational arithmetic-logic unit for an 8-bit datapath. It takes two operands and a 3-bit operation code and returns an 8-bit result together with four status bits: zero, negative, carry and signed overflow. One adder serves both addition and subtraction. For subtraction the second operand is inverted and the carry-in is forced to one.

The flags describe only the current result and are not stored inside the block. The carry flag holds the carry out of the sign bit. After a subtraction it reads as "no borrow", so an unsigned A < B shows up as carry = 0. Overflow flags a signed result that does not fit. For the bitwise and pass-through operations, carry and overflow are forced low, while zero and negative still come from the result. A surrounding sequencer can register the flags or feed them straight into branch-condition logic.

Top module: `alu8_core`

## Requirements
- R1: With operation code 000 (add), the result is the low 8 bits of A + B.
- R2: With operation code 001 (subtract), the result is A − B modulo 256. It is formed as A + ~B + 1.
- R3: Carry for code 000 is the ninth bit of the unsigned sum A + B. Carry for code 001 is 1 exactly when A ≥ B as unsigned numbers, and 0 when a borrow occurs.
- R4: Overflow for codes 000 and 001 is 1 exactly when the true signed sum or difference of A and B lies outside −128..127. Operands whose adder inputs differ in sign never set it.
- R5: Zero is 1 exactly when all 8 result bits are 0, regardless of the carry. For example, 0x80 + 0x80 gives zero = 1, carry = 1 and overflow = 1.
- R6: Negative always equals result bit 7.
- R7: The bitwise and pass-through codes produce the following results:
  - 010 gives A AND B.
  - 011 gives A OR B.
  - 100 gives A XOR B.
  - 101 gives B unchanged.
- R8: For codes 010 through 101, carry and overflow are both 0.
- R9: For the unused codes 110 and 111, the result is 0x00 and all four flags are 0. Zero is cleared in this case even though the result is zero.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (see R1, R2, R7, R9) |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Operation result |
| flag_z | output | 1 | Result is all zeros |
| flag_n | output | 1 | Copy of result bit 7 |
| flag_c | output | 1 | Carry out of bit 7 (no-borrow on subtract) |
| flag_v | output | 1 | Signed overflow |

## Verification
The assertions are immediate checks evaluated on the settled combinational outputs. They take the operands and the operation code to be fully defined two-state values that are held steady while the outputs are judged. The bench changes inputs only just after a rising clock edge and compares results only at the falling edge, so every assertion and every comparison sees settled logic. Add and subtract are swept over all 65,536 operand pairs. The bitwise operations run every B value against a spread of A values, and the unused codes are driven with varied operands to confirm that nothing leaks through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int unsigned OP_W = 3;

   localparam logic [OP_W-1:0] OP_ADD   = 3'b000;
   localparam logic [OP_W-1:0] OP_SUB   = 3'b001;
   localparam logic [OP_W-1:0] OP_AND   = 3'b010;
   localparam logic [OP_W-1:0] OP_OR    = 3'b011;
   localparam logic [OP_W-1:0] OP_XOR   = 3'b100;
   localparam logic [OP_W-1:0] OP_PASSB = 3'b101;

   typedef enum logic [1:0] {
      CLS_ARITH = 2'd0,
      CLS_LOGIC = 2'd1,
      CLS_NONE  = 2'd2
   } op_class_e;

   function automatic op_class_e classify(input logic [OP_W-1:0] op);
      case (op)
         OP_ADD, OP_SUB:                    classify = CLS_ARITH;
         OP_AND, OP_OR, OP_XOR, OP_PASSB:   classify = CLS_LOGIC;
         default:                           classify = CLS_NONE;
      endcase
   endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int unsigned WIDTH  = 8,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] in_x,
   input  logic [WIDTH-1:0] in_y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             carry_msb_in,
   output logic             carry_out
);

   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu8_adder: WIDTH must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]       = in_x[i] ^ in_y[i] ^ chain[i];
         assign chain[i+1]   = (in_x[i] & in_y[i]) | (chain[i] & (in_x[i] ^ in_y[i]));
      end
      assign carry_msb_in = chain[MSB];
      assign carry_out    = chain[WIDTH];

      // R3: the gate-level chain must agree with a wide arithmetic sum
      always_comb begin
         a_r3_chain_matches_sum: assert ({carry_out, sum} ==
            ({1'b0, in_x} + {1'b0, in_y} + {{WIDTH{1'b0}}, cin}))
            else $error("adder chain disagrees with wide sum");
      end
   end else begin : g_behav
      logic [WIDTH-1:0] low_part;
      logic [WIDTH:0]   full;
      assign low_part     = {1'b0, in_x[MSB-1:0]} + {1'b0, in_y[MSB-1:0]}
                            + {{(WIDTH-1){1'b0}}, cin};
      assign full         = {1'b0, in_x} + {1'b0, in_y} + {{WIDTH{1'b0}}, cin};
      assign sum          = full[MSB:0];
      assign carry_msb_in = low_part[MSB];
      assign carry_out    = full[WIDTH];
   end

   // R4: carry-pair overflow equals the sign-flip rule on the adder inputs
   always_comb begin
      a_r4_overflow_sign_rule: assert ((carry_msb_in ^ carry_out) ==
         ((in_x[MSB] == in_y[MSB]) && (sum[MSB] != in_x[MSB])))
         else $error("overflow carry pair disagrees with sign rule");
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [OP_W-1:0]  op,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      case (op)
         OP_AND:   res = in_a & in_b;
         OP_OR:    res = in_a | in_b;
         OP_XOR:   res = in_a ^ in_b;
         OP_PASSB: res = in_b;
         default:  res = '0;
      endcase
   end

   // R7: pass-through leaves B untouched
   always_comb begin
      if (op == OP_PASSB) begin
         a_r7_pass_b: assert (res == in_b) else $error("pass-through altered B");
      end
   end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu8_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  op_class_e        cls,
   input  logic [WIDTH-1:0] arith_res,
   input  logic [WIDTH-1:0] logic_res,
   input  logic             carry_msb_in,
   input  logic             carry_out,
   output logic [WIDTH-1:0] res,
   output logic             z,
   output logic             n,
   output logic             c,
   output logic             v
);

   localparam int unsigned MSB = WIDTH - 1;

   always_comb begin
      res = '0;
      z   = 1'b0;
      n   = 1'b0;
      c   = 1'b0;
      v   = 1'b0;
      case (cls)
         CLS_ARITH: begin
            res = arith_res;
            c   = carry_out;
            v   = carry_msb_in ^ carry_out;
            z   = ~|arith_res;
            n   = arith_res[MSB];
         end
         CLS_LOGIC: begin
            res = logic_res;
            z   = ~|logic_res;
            n   = logic_res[MSB];
         end
         default: ;
      endcase
   end

   // R5/R6: a zero result can never look negative
   always_comb begin
      a_r5_zero_not_neg: assert (!(z && n)) else $error("zero and negative both set");
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_c,
   output logic             flag_v
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu8_core: WIDTH must be at least 2");
   end

   op_class_e        cls;
   logic             do_sub;
   logic [WIDTH-1:0] adder_y;
   logic [WIDTH-1:0] arith_sum;
   logic [WIDTH-1:0] logic_out;
   logic             c_msb_in;
   logic             c_out;

   assign cls     = classify(op_sel);
   assign do_sub  = (op_sel == OP_SUB);
   assign adder_y = do_sub ? ~opnd_b : opnd_b;

   alu8_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .in_x         (opnd_a),
      .in_y         (adder_y),
      .cin          (do_sub),
      .sum          (arith_sum),
      .carry_msb_in (c_msb_in),
      .carry_out    (c_out)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .op   (op_sel),
      .in_a (opnd_a),
      .in_b (opnd_b),
      .res  (logic_out)
   );

   alu8_status #(.WIDTH(WIDTH)) u_status (
      .cls          (cls),
      .arith_res    (arith_sum),
      .logic_res    (logic_out),
      .carry_msb_in (c_msb_in),
      .carry_out    (c_out),
      .res          (result),
      .z            (flag_z),
      .n            (flag_n),
      .c            (flag_c),
      .v            (flag_v)
   );

   always_comb begin
      // R3: subtract carry reads as no-borrow
      if (op_sel == OP_SUB) begin
         a_r3_sub_no_borrow: assert (flag_c == (opnd_a >= opnd_b))
            else $error("subtract carry is not the no-borrow bit");
      end
      // R8: bitwise operations clear carry and overflow
      if (cls == CLS_LOGIC) begin
         a_r8_logic_clear: assert (!flag_c && !flag_v)
            else $error("logic op left carry or overflow set");
      end
      // R9: unused codes are silent
      if (cls == CLS_NONE) begin
         a_r9_unused_quiet: assert (result == '0 && !flag_z && !flag_n && !flag_c && !flag_v)
            else $error("unused code produced output");
      end
   end

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

   typedef struct packed {
      logic [2:0] op;
      logic [7:0] a;
      logic [7:0] b;
      logic [7:0] res;
      logic       z;
      logic       n;
      logic       c;
      logic       v;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_sel = 3'b000;
   logic [7:0] opnd_a = 8'h00;
   logic [7:0] opnd_b = 8'h00;
   logic [7:0] result;
   logic       flag_z, flag_n, flag_c, flag_v;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   item_t exp_q[$];

   always #4 clk = ~clk;

   alu8_core i_alu8_core (
      .op_sel (op_sel),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .result (result),
      .flag_z (flag_z),
      .flag_n (flag_n),
      .flag_c (flag_c),
      .flag_v (flag_v)
   );

   task automatic check(input string tag, input int got, input int exp, input item_t it);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s op=%b a=%h b=%h actual=%0h expected=%0h",
                  tag, it.op, it.a, it.b, got, exp);
      end
   endtask

   function automatic item_t model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
      item_t it;
      int ua, ub, sa, sb, t;
      ua = int'(a);  ub = int'(b);
      sa = (ua > 127) ? ua - 256 : ua;
      sb = (ub > 127) ? ub - 256 : ub;
      it = '0;
      it.op = op; it.a = a; it.b = b;
      case (op)
         3'b000: begin
            t = ua + ub;
            it.res = t[7:0];
            it.c = (t > 255);
            it.v = ((sa + sb) > 127) || ((sa + sb) < -128);
         end
         3'b001: begin
            t = ua - ub;
            it.res = t[7:0];
            it.c = (ua >= ub);
            it.v = ((sa - sb) > 127) || ((sa - sb) < -128);
         end
         3'b010: it.res = a & b;
         3'b011: it.res = a | b;
         3'b100: it.res = a ^ b;
         3'b101: it.res = b;
         default: it.res = 8'h00;
      endcase
      if (op <= 3'b101) begin
         it.z = (it.res == 8'h00);
         it.n = it.res[7];
      end
      return it;
   endfunction

   task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
      @(posedge clk);
      #1;
      op_sel = op; opnd_a = a; opnd_b = b;
      exp_q.push_back(model(op, a, b));
   endtask

   // monitor: scoreboard pop and compare at the falling edge
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         item_t it;
         string rtag, ctag, vtag;
         it = exp_q.pop_front();
         case (it.op)
            3'b000: rtag = "R1";
            3'b001: rtag = "R2";
            3'b110, 3'b111: rtag = "R9";
            default: rtag = "R7";
         endcase
         if (it.op <= 3'b001) begin ctag = "R3"; vtag = "R4"; end
         else if (it.op <= 3'b101) begin ctag = "R8"; vtag = "R8"; end
         else begin ctag = "R9"; vtag = "R9"; end
         check(rtag, int'(result), int'(it.res), it);
         check(ctag, int'(flag_c), int'(it.c), it);
         check(vtag, int'(flag_v), int'(it.v), it);
         check((it.op > 3'b101) ? "R9" : "R5", int'(flag_z), int'(it.z), it);
         check((it.op > 3'b101) ? "R9" : "R6", int'(flag_n), int'(it.n), it);
      end
   end

   initial begin
      item_t r0;
      repeat (3) @(posedge clk);
      // reset state: all-zero inputs with add give zero result, Z set (R5)
      @(negedge clk);
      r0 = model(3'b000, 8'h00, 8'h00);
      check("R5", int'(result), 0, r0);
      check("R5", int'(flag_z), 1, r0);
      rst_n = 1'b1;

      // R5 corner: 0x80 + 0x80 -> zero, carry, overflow all set
      drive(3'b000, 8'h80, 8'h80);
      // R4 corner: 0x7F + 0x01 overflows positive
      drive(3'b000, 8'h7F, 8'h01);
      // R3 corner: equal subtract gives no borrow
      drive(3'b001, 8'h42, 8'h42);
      // R9 corner: unused code with zero operands leaves Z clear
      drive(3'b110, 8'h00, 8'h00);

      // R1..R6 exhaustive add and subtract
      for (int op = 0; op < 2; op++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
               drive(op[2:0], a[7:0], b[7:0]);

      // R7/R8 bitwise codes over a spread of A
      for (int op = 2; op < 6; op++)
         for (int a = 0; a < 256; a += 17)
            for (int b = 0; b < 256; b++)
               drive(op[2:0], a[7:0], b[7:0]);

      // R9 unused codes
      for (int op = 6; op < 8; op++)
         for (int b = 0; b < 256; b++)
            drive(op[2:0], 8'(b * 37), b[7:0]);

      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

endmodule